// File: doc/BRIEF.md
# Per-Core Power Zone Controller

This block holds one 32-bit control and status word for the power zone of a single processor core. Software writes the word through a plain write port and reads it back on a combinational read bus. When the manual-mode bit is set, the control bits drive the core's clock enable, reset release, memory power, auxiliary power switch and isolation lines directly. When the manual-mode bit is clear, those lines stay in their safe off state.

Four read-only status fields report how far the zone has moved: memory power, power-gate state, reset state, and a combined on/off indication. A status bit does not follow its control immediately. It changes only after its cause has stayed steady for a programmable number of cycles. Software therefore has to poll status between steps of a power-up or power-down sequence, as it would with real switches.

The power-gate status needs the clock enable to be on before it can rise. Once it has risen, it stays up until the auxiliary switch is turned off. The power-down and power-up request bits are plain stored flags.

Top module: `pwr_zone_ctrl`

## Requirements
- R1: Once reset is released, the word reads 0x8200_0000: reset state (bit 31) is 1, power-off state (bit 25) is 1, and every other bit is 0. The core lines are clk_en=0, rst_n=0, iso=1, mem_pwr=0 and pwr_sw=0.
- R2: A write stores only bits 0, 1, 4, 5, 6, 7, 9, 10 and 12, and these read back as written in the next cycle. Written values at all other positions are dropped. Reserved positions always read 0. Status positions 25, 26, 28, 29 and 31 show only status.
- R3: While bit 7 (manual mode) is 0, the core lines are held at clk_en=0, rst_n=0, mem_pwr=0, pwr_sw=0 and iso=1, whatever the other control bits hold.
- R4: While bit 7 is 1, each core line follows its control bit from the cycle after the write: clk_en follows bit 0, rst_n follows bit 1, mem_pwr follows bit 4, pwr_sw follows bit 5 and iso follows bit 6.
- R5: While bit 12 (block reset) is 1, core rst_n is 0, even when bit 1 is 1.
- R6: Memory power state (bit 29) takes the value of core mem_pwr once mem_pwr has differed from it for SETTLE_CYC consecutive cycles. A difference that ends sooner restarts the count and leaves bit 29 unchanged.
- R7: Power-gate state (bit 28) rises once pwr_sw and clk_en have both been 1 for SETTLE_CYC cycles. After that it stays 1 while pwr_sw stays 1, even if clk_en drops. It falls once pwr_sw has been 0 for SETTLE_CYC cycles.
- R8: Reset state (bit 31) becomes 0 once core rst_n has been 1 for SETTLE_CYC cycles. It becomes 1 once core rst_n has been 0 for SETTLE_CYC cycles.
- R9: Bit 26 (on) is 1 exactly when bits 28 and 29 are both 1. Bit 25 (off) is 1 exactly when bits 28 and 29 are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Data to write |
| rd_data | output | 32 | Current control and status word |
| core_clk_en | output | 1 | Core clock enable |
| core_rst_n | output | 1 | Core reset, active low (1 = released) |
| core_iso | output | 1 | Core output isolation (1 = isolated) |
| core_mem_pwr | output | 1 | Core memory power enable |
| core_pwr_sw | output | 1 | Auxiliary power switch enable |

## Verification
The assertions assume two things about the inputs:
- reset is applied before the first write;
- SETTLE_CYC is at least 1.

They assume nothing about when writes arrive or what data they carry. The stimulus follows this. It drives wr_en and wr_data on the falling edge and writes at arbitrary cycles. Random data covers reserved and status positions. Writes are spaced so that some settling counts complete and others are cut short by a later write.

// File: rtl/pzc_pkg.sv
package pzc_pkg;
  localparam int B_CLKEN  = 0;
  localparam int B_RSTREL = 1;
  localparam int B_MEMPWR = 4;
  localparam int B_SWITCH = 5;
  localparam int B_ISO    = 6;
  localparam int B_MANUAL = 7;
  localparam int B_DNREQ  = 9;
  localparam int B_UPREQ  = 10;
  localparam int B_BLKRST = 12;
  localparam int S_OFF    = 25;
  localparam int S_ON     = 26;
  localparam int S_GATE   = 28;
  localparam int S_MEM    = 29;
  localparam int S_RST    = 31;

  localparam logic [31:0] CTRL_MASK = (32'd1 << B_CLKEN) | (32'd1 << B_RSTREL) |
                                      (32'd1 << B_MEMPWR) | (32'd1 << B_SWITCH) |
                                      (32'd1 << B_ISO) | (32'd1 << B_MANUAL) |
                                      (32'd1 << B_DNREQ) | (32'd1 << B_UPREQ) |
                                      (32'd1 << B_BLKRST);

  typedef struct packed {
    logic clk_en;
    logic rst_n;
    logic iso;
    logic mem_pwr;
    logic pwr_sw;
  } core_drv_t;

  // index of each settled status inside the status vector
  localparam int ST_MEM  = 0;
  localparam int ST_GATE = 1;
  localparam int ST_RST  = 2;
  localparam int N_ST    = 3;
endpackage

// File: rtl/pzc_ctrl_reg.sv
module pzc_ctrl_reg
  import pzc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] ctrl_q,
  output core_drv_t   drv
);
  logic manual;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & CTRL_MASK;
  end

  always_comb begin
    manual      = ctrl_q[B_MANUAL];
    drv.clk_en  = manual & ctrl_q[B_CLKEN];
    drv.rst_n   = manual & ctrl_q[B_RSTREL] & ~ctrl_q[B_BLKRST];
    drv.iso     = ~manual | ctrl_q[B_ISO];
    drv.mem_pwr = manual & ctrl_q[B_MEMPWR];
    drv.pwr_sw  = manual & ctrl_q[B_SWITCH];
  end

  AST_NO_RESERVED_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_q & ~CTRL_MASK) == 32'd0)); // R2
  AST_BLKRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_BLKRST]) |=> !drv.rst_n); // R5
endmodule

// File: rtl/pzc_settle.sv
module pzc_settle #(
  parameter int   DELAY = 16,
  parameter logic INIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt,
  output logic st
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= INIT;
      cnt <= '0;
    end else if (tgt == st) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      st  <= tgt;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R6
  AST_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != LAST) |=> $stable(st)); // R6
endmodule

// File: rtl/pzc_status.sv
module pzc_status
  import pzc_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  core_drv_t   drv,
  output logic [31:0] stat_word
);
  localparam logic [N_ST-1:0] INITS = N_ST'(1) << ST_RST;

  logic [N_ST-1:0] tgt;
  logic [N_ST-1:0] st;

  always_comb begin
    tgt[ST_MEM]  = drv.mem_pwr;
    // gate needs clock enable to come up, then holds until the switch drops
    tgt[ST_GATE] = drv.pwr_sw & (drv.clk_en | st[ST_GATE]);
    tgt[ST_RST]  = ~drv.rst_n;
  end

  for (genvar i = 0; i < N_ST; i++) begin : g_settle
    pzc_settle #(.DELAY(SETTLE_CYC), .INIT(INITS[i])) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .tgt  (tgt[i]),
      .st   (st[i])
    );
  end

  always_comb begin
    stat_word         = '0;
    stat_word[S_RST]  = st[ST_RST];
    stat_word[S_MEM]  = st[ST_MEM];
    stat_word[S_GATE] = st[ST_GATE];
    stat_word[S_ON]   = st[ST_GATE] & st[ST_MEM];
    stat_word[S_OFF]  = ~st[ST_GATE] & ~st[ST_MEM];
  end

  AST_GATE_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[ST_GATE]) |-> $past(drv.pwr_sw)); // R7
  AST_GATE_NEEDS_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[ST_GATE]) |-> $past(drv.clk_en)); // R7
  AST_RST_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st[ST_RST]) |-> $past(drv.rst_n)); // R8
endmodule

// File: rtl/pwr_zone_ctrl.sv
module pwr_zone_ctrl
  import pzc_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        core_clk_en,
  output logic        core_rst_n,
  output logic        core_iso,
  output logic        core_mem_pwr,
  output logic        core_pwr_sw
);
  logic [31:0] ctrl_q;
  logic [31:0] stat_word;
  core_drv_t   drv;

  pzc_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q),
    .drv    (drv)
  );

  pzc_status #(.SETTLE_CYC(SETTLE_CYC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv      (drv),
    .stat_word(stat_word)
  );

  assign rd_data      = ctrl_q | stat_word;
  assign core_clk_en  = drv.clk_en;
  assign core_rst_n   = drv.rst_n;
  assign core_iso     = drv.iso;
  assign core_mem_pwr = drv.mem_pwr;
  assign core_pwr_sw  = drv.pwr_sw;

  AST_AUTO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_MANUAL] |-> (core_iso && !core_clk_en && !core_rst_n &&
                            !core_mem_pwr && !core_pwr_sw)); // R3
  AST_ON_OFF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[S_ON] && rd_data[S_OFF])); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~(CTRL_MASK | 32'hB600_0000)) == 32'd0); // R2
endmodule

// File: tb/sim_pwr_zone_ctrl.sv
module sim_pwr_zone_ctrl;
  localparam int DLY = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        core_clk_en, core_rst_n, core_iso, core_mem_pwr, core_pwr_sw;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  string tag = "R1";

  logic [31:0] m_ctrl;
  bit m_mem, m_gate, m_rst;
  int c_mem, c_gate, c_rst;

  always #5 clk = ~clk;

  pwr_zone_ctrl #(.SETTLE_CYC(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_clk_en(core_clk_en), .core_rst_n(core_rst_n), .core_iso(core_iso),
    .core_mem_pwr(core_mem_pwr), .core_pwr_sw(core_pwr_sw)
  );

  // expected core lines {clk_en, rst_n, iso, mem_pwr, pwr_sw}, per R3/R4/R5
  function automatic logic [4:0] exp_lines(logic [31:0] c);
    bit man = c[7];
    return {man & c[0], man & c[1] & ~c[12], ~man | c[6], man & c[4], man & c[5]};
  endfunction

  // expected word: stored bits per R2, status per R6-R9
  function automatic logic [31:0] exp_word();
    logic [31:0] e = m_ctrl;
    e[31] = m_rst;
    e[29] = m_mem;
    e[28] = m_gate;
    e[26] = m_gate & m_mem;
    e[25] = !m_gate & !m_mem;
    return e;
  endfunction

  function automatic void settle(inout bit s, inout int c, input bit t);
    if (t == s) c = 0;
    else if (c == DLY - 1) begin s = t; c = 0; end
    else c = c + 1;
  endfunction

  task automatic model_edge(bit we, logic [31:0] d);
    logic [4:0] l = exp_lines(m_ctrl);
    bit tm = l[1];
    bit tg = l[0] & (l[4] | m_gate);
    bit tr = !l[3];
    settle(m_mem, c_mem, tm);
    settle(m_gate, c_gate, tg);
    settle(m_rst, c_rst, tr);
    if (we) m_ctrl = d & 32'h0000_16F3;
  endtask

  task automatic check();
    logic [31:0] ew = exp_word();
    logic [4:0]  el = exp_lines(m_ctrl);
    logic [4:0]  al = {core_clk_en, core_rst_n, core_iso, core_mem_pwr, core_pwr_sw};
    n_vec++;
    if (rd_data !== ew || al !== el) begin
      n_bad++;
      $display("FAIL %s word=%h exp=%h lines=%b exp=%b at %0t", tag, rd_data, ew, al, el, $time);
    end
  endtask

  task automatic step(bit we, logic [31:0] d);
    wr_en = we;
    wr_data = d;
    model_edge(we, d);
    @(negedge clk);
    check();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_ctrl = '0; m_mem = 0; m_gate = 0; m_rst = 1;
    c_mem = 0; c_gate = 0; c_rst = 0;
    tag = "R1"; check();
    idle(3);

    // R2 R5: all ones, only writable bits kept, block reset forces rst_n low
    tag = "R2 R5"; step(1'b1, 32'hFFFF_FFFF);
    idle(DLY + 4);
    // R3: manual off keeps lines safe
    tag = "R3"; step(1'b1, 32'h0000_0073);
    idle(DLY + 4);

    // R4 R6 R7 R8 R9: ordered power-up
    tag = "R4 R7 R9"; step(1'b1, 32'h0000_00E0);
    idle(4);
    tag = "R6"; step(1'b1, 32'h0000_00F0);
    idle(DLY + 2);
    tag = "R7"; step(1'b1, 32'h0000_00F1);
    idle(DLY + 2);
    tag = "R8"; step(1'b1, 32'h0000_00B3);
    idle(DLY + 2);

    // R7: gate holds while switch stays on, clock enable dropped
    tag = "R7 hold"; step(1'b1, 32'h0000_00B2);
    idle(DLY + 2);
    // R6: short memory-off pulse is filtered
    tag = "R6 glitch"; step(1'b1, 32'h0000_00A2);
    idle(DLY / 2);
    step(1'b1, 32'h0000_00B2);
    idle(DLY + 2);
    // R7 R9: switch off, gate falls
    tag = "R7 fall"; step(1'b1, 32'h0000_0092);
    idle(DLY + 2);
    tag = "R8 R9 down"; step(1'b1, 32'h0000_0080);
    idle(DLY + 2);

    // random mix
    tag = "random R2-mix";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 6) == 0;
      logic [31:0] d = $urandom;
      if (($urandom % 4) != 0) d = (d & 32'h0000_0073) | 32'h0000_0080;
      step(we, d);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule